// File: doc/BRIEF.md
# Serial Six-Bit Pattern Matcher

This block watches a serial bit stream and reports when the six most recent bits form the fixed pattern 0,1,0,0,1,0 in order of arrival. One bit is sampled on every rising clock edge into a six-bit window. The newest bit enters at the most significant end, and the older contents move one place toward bit 0. The oldest bit of the window is therefore always in bit 0.

A comparator on the window drives the match flag with no register in between. The flag is high during the clock cycle after the edge that captured the sixth matching bit. A synchronous, active-high reset clears the window to all zeros. After reset, those zeros count as received history, so a match can appear with fewer than six fresh bits. Matches that overlap are all reported. The pattern and the width are parameters.

Top module: `serial_pattern_match`

## Requirements
- R1: While `rst` is 1 at a rising edge, the window is cleared to all zeros, so `hit` is 0 in the cycle that follows.
- R2: Reset takes priority over the serial input. A 1 on `ser_in` during a reset edge does not enter the window.
- R3: At each rising edge without reset, `ser_in` is stored in bit 5 and bits 5..1 move to bits 4..0. Bit 0 holds the oldest bit.
- R4: `hit` is 1 exactly when the window equals 6'b010010 (bit 5 on the left). In arrival order this is 0,1,0,0,1,0.
- R5: `hit` has no register of its own. It is high in the cycle right after the edge that completes the pattern, and it drops at the next edge unless the window still matches.
- R6: Overlapping matches are each reported. For the stream 0,1,0,0,1,0,0,1,0, `hit` is high after the 6th bit and again after the 9th bit.
- R7: The zeros left by reset count as history. After reset, the bits 1,0,0,1,0 raise `hit` after the fifth of them.
- R8: A window that differs from the pattern in any single position gives `hit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of the window |
| ser_in | input | 1 | Serial data bit, sampled every edge |
| hit | output | 1 | High while the window holds the pattern |

## Verification
Every result is due one edge after the stimulus that causes it. A bit or a reset applied before edge N shows its effect on `hit` just after edge N, with no added latency from the flag. The driver changes inputs on the falling edge and pushes the value that a window model predicts for the next rising edge. The monitor compares `hit` one nanosecond after that rising edge, so each expected item meets the cycle it describes.

// File: rtl/serial_pattern_match.sv
module serial_pattern_match #(
  parameter int W = 6,
  parameter logic [W-1:0] PAT = 6'b010010
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic hit
);

  logic [W-1:0] win;

  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {ser_in, win[W-1:1]};
  end

  assign hit = (win == PAT);

endmodule

// File: rtl/serial_pattern_match_chk.sv
module serial_pattern_match_chk #(
  parameter int W = 6,
  parameter logic [W-1:0] PAT = 6'b010010
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_in,
  input logic [W-1:0] win,
  input logic         hit
);

  // R1
  window_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (win == '0 && !hit));

  // R2
  reset_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && $past(ser_in) |-> !win[W-1]);

  // R3
  newest_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> win[W-1] == $past(ser_in));

  // R3
  older_move_down_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> win[W-2:0] == $past(win[W-1:1]));

  // R5
  hit_from_last_bit_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!$past(rst) && $past(ser_in) == PAT[W-1]));

endmodule

bind serial_pattern_match serial_pattern_match_chk #(.W(W), .PAT(PAT)) chk (
  .clk(clk), .rst(rst), .ser_in(ser_in), .win(win), .hit(hit)
);

// File: tb/serial_pattern_match_test.sv
`timescale 1ns/1ps
module serial_pattern_match_test;
  localparam int W = 6;
  localparam logic [W-1:0] PAT = 6'b010010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic hit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;
  logic exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  serial_pattern_match uut (.clk(clk), .rst(rst), .ser_in(ser_in), .hit(hit));

  task automatic step(input logic r, input logic b, input string tag);
    @(negedge clk);
    rst = r;
    ser_in = b;
    if (r) model = '0;
    else   model = {b, model[W-1:1]};
    exp_q.push_back(model == PAT);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(1'b0, bits[i], tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (hit !== e) begin
          bad++;
          $display("FAIL %s: hit=%b expected=%b at %0t", t, hit, e, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset state
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    // R2: ones during reset must not enter
    step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, "R2");
    // R7: reset zeros form part of the window
    send(16'b10010, 5, "R7");
    // R5: flag drops when the window moves on
    send(16'b1, 1, "R5");
    step(1'b1, 1'b0, "R1");
    // R4: full pattern in arrival order
    send(16'b111111, 6, "R3");
    send(16'b010010, 6, "R4");
    // R6: overlapping matches
    step(1'b1, 1'b0, "R1");
    send(16'b111111, 6, "R3");
    send(16'b010010010, 9, "R6");
    send(16'b010010010010, 12, "R6");
    // R8: single-bit near misses
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] p;
      p = PAT ^ (6'b1 << k);
      send(16'b111111, 6, "R8");
      send({10'b0, p}, 6, "R8");
    end
    // R3: random streams with embedded patterns
    for (int j = 0; j < 400; j++) begin
      if (($urandom % 23) == 0) send(16'b010010, 6, "R3");
      else if (($urandom % 97) == 0) step(1'b1, 1'($urandom), "R2");
      else step(1'b0, 1'($urandom), "R3");
    end
    step(1'b0, 1'b0, "R3");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule